// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block sits in front of a 12-bit multiplying DAC that sets the gain of an audio path. It keeps the gain word in two stages, so that a gain change is heard only when the waveform is near zero and does not click. The host shifts a new word in serially, MSB first, and then commits it to a staging register. It then gives a single-cycle arm pulse. While the block is armed, it watches a stream of signed 16-bit audio samples. The first valid sample whose magnitude is at or below a programmable threshold fires a one-cycle load strobe. That strobe copies the staged word into the active gain and clears the arm in the same cycle.

Because the block waits for the audio to pass near zero, the time from arm to update has no upper bound. The block therefore suits snapshot-style gain changes in EQs, filters and level settings, and does not suit fast dynamics control. The host can cancel a pending update with a disarm pulse. While the block is armed, the serial loader is locked, so the staged word cannot change under a pending transfer.

Top module: `zc_gain_update`

## Requirements
- R1: After reset, `gain_out` is 0, `armed` is 0, `load_done` is 0 and the window threshold equals the parameter `THR_RST` (default 64).
- R2: Each cycle with `ser_en` high shifts `ser_data` into a 12-bit shift register, MSB first. After 12 shifts, a `ser_latch` pulse copies the shift register into the staging register. Shifting and latching never change `gain_out`.
- R3: A single-cycle `arm_pulse` sets `armed` at the next clock edge. `armed` then stays high with the input low, until a transfer or a disarm clears it.
- R4: A `disarm_pulse` clears `armed` at the next edge and no transfer occurs. When it arrives in the same cycle as `arm_pulse` or as a qualifying sample, the disarm wins.
- R5: When `armed` is 1 and a valid sample qualifies, the same clock edge does three things. It loads `gain_out` with the staged word, it clears `armed`, and it raises `load_done` for exactly one cycle.
- R6: While armed, an invalid sample (`smp_valid` low) or a sample outside the window causes no transfer, and `armed` stays 1.
- R7: A sample qualifies when |sample| <= threshold, with the boundary included. Negative samples are judged by magnitude, and -32768 has magnitude 32768.
- R8: A qualifying sample that arrives in the same cycle as the `arm_pulse` that arms the block does not trigger a transfer. The next qualifying sample does.
- R9: While `armed` is 1, `ser_en` and `ser_latch` are ignored, and the shift and staging registers keep their contents.
- R10: A cycle with `thr_we` high loads `thr_in` into the threshold register, which takes effect for samples in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data | input | 1 | Serial gain bit |
| ser_en | input | 1 | Shift enable for `ser_data` |
| ser_latch | input | 1 | Commit the shift register to the staging register |
| arm_pulse | input | 1 | Request a gain transfer at the next near-zero sample |
| disarm_pulse | input | 1 | Cancel a pending transfer |
| thr_we | input | 1 | Write enable for the window threshold |
| thr_in | input | 16 | New threshold (unsigned magnitude) |
| smp_valid | input | 1 | Audio sample strobe |
| smp_data | input | 16 | Audio sample, two's complement |
| gain_out | output | 12 | Active gain word to the DAC |
| armed | output | 1 | Transfer pending |
| load_done | output | 1 | One-cycle pulse on the cycle `gain_out` takes a new value |

## Verification
The bench probes the window edges: thresholds exactly equal to |sample| on both signs, one count above, and the -32768 sample against thresholds of 32767 and 32768. A comparator built with `<` or with a 16-bit magnitude would miss or fire at these points. It collides an arm with a qualifying sample, and separately a disarm with one. A design that looks at the unregistered arm request, or that lets the transfer beat the disarm, would raise an unexpected `load_done`. It feeds serial words while the block is armed and later commits the shift register without new bits. A loader that is not locked would then reveal the discarded word on `gain_out`.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  // Action chosen for the arm latch in a cycle.
  typedef enum logic [1:0] {
    ARM_HOLD  = 2'd0,
    ARM_SET   = 2'd1,
    ARM_CLEAR = 2'd2,
    ARM_FIRE  = 2'd3
  } arm_act_e;
endpackage

// File: rtl/zcg_serial_stage.sv
module zcg_serial_stage #(
  parameter int unsigned GAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              ser_latch,
  output logic [GAIN_W-1:0] staged_o
);
  logic [GAIN_W-1:0] shift_q, shift_d;
  logic [GAIN_W-1:0] stage_q, stage_d;
  logic              shift_ce, stage_ce;

  always_comb begin
    shift_ce = ser_en && !lock;
    stage_ce = ser_latch && !lock;
    shift_d  = {shift_q[GAIN_W-2:0], ser_data};
    stage_d  = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      stage_q <= '0;
    end else begin
      if (shift_ce) shift_q <= shift_d;
      if (stage_ce) stage_q <= stage_d;
    end
  end

  assign staged_o = stage_q;
endmodule

// File: rtl/zcg_window.sv
module zcg_window #(
  parameter int unsigned SMP_W   = 16,
  parameter logic [SMP_W-1:0] THR_RST = 16'd64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic [SMP_W-1:0] thr_in,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic [SMP_W-1:0] thr_o,
  output logic             hit_o
);
  localparam int unsigned MAG_W = SMP_W + 1;

  logic [SMP_W-1:0] thr_q;
  logic [MAG_W-1:0] ext, mag;

  always_comb begin
    ext   = {smp_data[SMP_W-1], smp_data};
    mag   = ext[MAG_W-1] ? (~ext + 1'b1) : ext;
    hit_o = smp_valid && (mag <= {1'b0, thr_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= THR_RST;
    else if (thr_we) thr_q <= thr_in;
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/zcg_arm_ctrl.sv
module zcg_arm_ctrl
  import zcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_pulse,
  input  logic disarm_pulse,
  input  logic hit,
  output logic armed_o,
  output logic fire_o
);
  logic     armed_q, armed_d;
  arm_act_e act;

  always_comb begin
    if (disarm_pulse)           act = ARM_CLEAR;
    else if (armed_q && hit)    act = ARM_FIRE;
    else if (arm_pulse)         act = ARM_SET;
    else                        act = ARM_HOLD;
    unique case (act)
      ARM_SET:            armed_d = 1'b1;
      ARM_CLEAR, ARM_FIRE: armed_d = 1'b0;
      default:            armed_d = armed_q;
    endcase
    fire_o = (act == ARM_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/zc_gain_update.sv
module zc_gain_update #(
  parameter int unsigned      GAIN_W  = 12,
  parameter int unsigned      SMP_W   = 16,
  parameter logic [SMP_W-1:0] THR_RST = 16'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              ser_latch,
  input  logic              arm_pulse,
  input  logic              disarm_pulse,
  input  logic              thr_we,
  input  logic [SMP_W-1:0]  thr_in,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic [GAIN_W-1:0] gain_out,
  output logic              armed,
  output logic              load_done
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_i_n;
  logic [GAIN_W-1:0] staged;
  logic [SMP_W-1:0]  thr_cur;
  logic              hit, fire, armed_w;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              done_q;

  // Reset asserts at once, releases after SYNC_N clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_N-1];

  zcg_serial_stage #(.GAIN_W(GAIN_W)) u_ser (
    .clk(clk), .rst_n(rst_i_n), .lock(armed_w),
    .ser_data(ser_data), .ser_en(ser_en), .ser_latch(ser_latch),
    .staged_o(staged)
  );

  zcg_window #(.SMP_W(SMP_W), .THR_RST(THR_RST)) u_win (
    .clk(clk), .rst_n(rst_i_n), .thr_we(thr_we), .thr_in(thr_in),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .thr_o(thr_cur), .hit_o(hit)
  );

  zcg_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_i_n), .arm_pulse(arm_pulse),
    .disarm_pulse(disarm_pulse), .hit(hit),
    .armed_o(armed_w), .fire_o(fire)
  );

  always_comb gain_d = staged;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gain_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (fire) gain_q <= gain_d;
      done_q <= fire;
    end
  end

  assign gain_out  = gain_q;
  assign armed     = armed_w;
  assign load_done = done_q;
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker #(
  parameter int unsigned GAIN_W = 12,
  parameter int unsigned SMP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_pulse,
  input logic              disarm_pulse,
  input logic              smp_valid,
  input logic [SMP_W-1:0]  smp_data,
  input logic [SMP_W-1:0]  thr_cur,
  input logic [GAIN_W-1:0] gain_out,
  input logic              armed,
  input logic              load_done
);
  logic [SMP_W:0] mag_now;
  always_comb begin
    mag_now = smp_data[SMP_W-1] ? ({1'b0, ~smp_data} + 1'b1) : {1'b0, smp_data};
  end

  // R5
  done_clears_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> ($past(armed) && !armed));

  // R2
  gain_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> $stable(gain_out));

  // R3
  arm_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(arm_pulse) && !$past(disarm_pulse)));

  // R4
  disarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disarm_pulse) |-> (!armed && !load_done));

  // R7
  window_inclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> ($past(smp_valid) && ($past(mag_now) <= {1'b0, $past(thr_cur)})));

  // R8
  no_same_cycle_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arm_pulse) && !$past(armed)) |-> !load_done);
endmodule

bind zc_gain_update zcg_checker #(.GAIN_W(GAIN_W), .SMP_W(SMP_W)) u_zcg_chk (
  .clk(clk), .rst_n(rst_n), .arm_pulse(arm_pulse), .disarm_pulse(disarm_pulse),
  .smp_valid(smp_valid), .smp_data(smp_data), .thr_cur(thr_cur),
  .gain_out(gain_out), .armed(armed), .load_done(load_done)
);

// File: tb/zc_gain_update_bench.sv
module zc_gain_update_bench;
  localparam int GW = 12;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_data = 1'b0, ser_en = 1'b0, ser_latch = 1'b0;
  logic          arm_pulse = 1'b0, disarm_pulse = 1'b0;
  logic          thr_we = 1'b0;
  logic [SW-1:0] thr_in = '0;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [GW-1:0] gain_out;
  logic          armed, load_done;

  int n_cmp = 0;
  int n_bad = 0;
  logic [GW-1:0] exp_q[$];

  always #4 clk = ~clk;

  zc_gain_update u_zc_gain_update (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_en(ser_en),
    .ser_latch(ser_latch), .arm_pulse(arm_pulse), .disarm_pulse(disarm_pulse),
    .thr_we(thr_we), .thr_in(thr_in), .smp_valid(smp_valid), .smp_data(smp_data),
    .gain_out(gain_out), .armed(armed), .load_done(load_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: each load_done pops one expected gain word.
  always @(negedge clk) begin
    if (rst_n && load_done) begin
      if (exp_q.size() == 0) chk("R5 unexpected load_done", 1, 0);
      else chk("R5 transferred gain", int'(gain_out), int'(exp_q.pop_front()));
    end
  end

  task automatic shift_word(input logic [GW-1:0] w);
    for (int i = GW - 1; i >= 0; i--) begin
      @(negedge clk); ser_en = 1'b1; ser_data = w[i];
    end
    @(negedge clk); ser_en = 1'b0; ser_data = 1'b0;
  endtask

  task automatic latch_word();
    @(negedge clk); ser_latch = 1'b1;
    @(negedge clk); ser_latch = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm_pulse = 1'b1;
    @(negedge clk); arm_pulse = 1'b0;
  endtask

  task automatic do_disarm();
    @(negedge clk); disarm_pulse = 1'b1;
    @(negedge clk); disarm_pulse = 1'b0;
  endtask

  task automatic set_thr(input logic [SW-1:0] t);
    @(negedge clk); thr_we = 1'b1; thr_in = t;
    @(negedge clk); thr_we = 1'b0;
  endtask

  // Driver: pushes the expected word before a sample that should transfer.
  task automatic sample(input logic v, input int s, input logic expect_fire,
                        input logic [GW-1:0] w);
    if (expect_fire) exp_q.push_back(w);
    @(negedge clk); smp_valid = v; smp_data = SW'(s);
    @(negedge clk); smp_valid = 1'b0; smp_data = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 gain_out", int'(gain_out), 0);
    chk("R1 armed", int'(armed), 0);
    chk("R1 load_done", int'(load_done), 0);
    // R1 default threshold 64: arm, 65 misses, -64 hits (staged 0)
    do_arm();
    sample(1'b1, 65, 1'b0, '0);
    chk("R1 thr default miss keeps arm", int'(armed), 1);
    sample(1'b1, -64, 1'b1, 12'h000);
    chk("R1 thr default hit clears arm", int'(armed), 0);

    // R10 threshold write
    set_thr(16'd100);

    // R2 serial load leaves gain untouched
    shift_word(12'hA5C);
    latch_word();
    chk("R2 gain unchanged after load", int'(gain_out), 0);
    chk("R2 no done during load", int'(load_done), 0);

    // R3 arm held
    do_arm();
    chk("R3 armed after pulse", int'(armed), 1);
    repeat (5) @(negedge clk);
    chk("R3 armed holds", int'(armed), 1);
    // R6 misses
    sample(1'b1, 500, 1'b0, '0);
    sample(1'b0, 0, 1'b0, '0);
    sample(1'b1, -101, 1'b0, '0);
    chk("R6 still armed", int'(armed), 1);
    chk("R6 gain unchanged", int'(gain_out), 0);
    // R7 negative boundary hits; R5 transfer
    sample(1'b1, -100, 1'b1, 12'hA5C);
    chk("R5 arm cleared", int'(armed), 0);
    @(negedge clk);
    chk("R5 done one cycle", int'(load_done), 0);

    // R7 positive boundary
    shift_word(12'h3F1);
    latch_word();
    do_arm();
    sample(1'b1, 101, 1'b0, '0);
    sample(1'b1, 100, 1'b1, 12'h3F1);
    chk("R7 gain at boundary", int'(gain_out), 'h3F1);

    // R9 loader locked while armed
    shift_word(12'h123);
    latch_word();
    do_arm();
    shift_word(12'hFFF);
    latch_word();
    sample(1'b1, 0, 1'b1, 12'h123);
    latch_word();
    do_arm();
    sample(1'b1, 3, 1'b1, 12'h123);
    chk("R9 ignored shift left no trace", int'(gain_out), 'h123);

    // R4 disarm
    shift_word(12'h456);
    latch_word();
    do_arm();
    do_disarm();
    chk("R4 disarmed", int'(armed), 0);
    sample(1'b1, 0, 1'b0, '0);
    chk("R4 gain kept", int'(gain_out), 'h123);
    // R4 disarm beats arm
    @(negedge clk); arm_pulse = 1'b1; disarm_pulse = 1'b1;
    @(negedge clk); arm_pulse = 1'b0; disarm_pulse = 1'b0;
    chk("R4 disarm beats arm", int'(armed), 0);
    // R4 disarm beats qualifying sample
    do_arm();
    @(negedge clk); disarm_pulse = 1'b1; smp_valid = 1'b1; smp_data = '0;
    @(negedge clk); disarm_pulse = 1'b0; smp_valid = 1'b0;
    chk("R4 disarm beats sample", int'(armed), 0);
    chk("R4 no transfer", int'(gain_out), 'h123);

    // R8 arm and qualifying sample in one cycle
    shift_word(12'h7E7);
    latch_word();
    @(negedge clk); arm_pulse = 1'b1; smp_valid = 1'b1; smp_data = 16'd5;
    @(negedge clk); arm_pulse = 1'b0; smp_valid = 1'b0; smp_data = '0;
    chk("R8 armed, no transfer", int'(armed), 1);
    chk("R8 gain kept", int'(gain_out), 'h123);
    sample(1'b1, -5, 1'b1, 12'h7E7);

    // R7 most negative sample, R10 threshold takes effect
    set_thr(16'd32767);
    do_arm();
    sample(1'b1, -32768, 1'b0, '0);
    chk("R7 -32768 outside 32767", int'(armed), 1);
    set_thr(16'd32768);
    sample(1'b1, -32768, 1'b1, 12'h7E7);
    chk("R10 new thr took effect", int'(armed), 0);

    repeat (3) @(negedge clk);
    chk("R5 all expected transfers seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule